// File: doc/BRIEF.md
# Fixed-Frame SPI Response Slave

This block is an SPI slave that answers one fixed transaction. An active-low select bounds each transaction. Inside it the master clocks a 16-bit header that the slave ignores, and then, with no pause, 32 more bits during which the slave shifts out a response word. The serial clock idles low. The master samples on the rising edge and the slave changes its output on the falling edge.

Local logic loads the response ahead of time into a holding register with a valid strobe. On select assertion the holding value is copied into a separate shift register. The serial side therefore never waits on the local side in mid-frame, and a late or missing load cannot stall the frame. Select and the serial clock pass through two-flop synchronisers into a system clock at least eight times faster than the serial clock. All edges are detected from the synchronised copies. A one-cycle pulse reports each frame that closes after exactly 48 bits, and a separate one-cycle pulse reports a frame that closes at any other bit count.

Top module: `fixed_frame_spi_slave`

## Requirements
- R1: While the synchronised select is inactive, `miso_oe_o` and `miso_o` are both 0. Serial clock edges seen with select high change no output. After reset, `frame_done_o` and `frame_err_o` are 0.
- R2: During the first 16 rising serial clock edges of a frame, and until the 16th edge has been counted, `miso_o` is 0.
- R3: The response is sent most significant bit first. Bit 31 appears once the 16th rising edge has been counted. After each falling edge that follows the 17th and each later rising edge, the next lower bit is presented. The master therefore samples bit 31-i at rising edge 17+i, for i = 0 to 31.
- R4: A `rsp_valid_i` pulse stores `rsp_data_i` in the holding register. A frame sends the holding value as it stood when select was asserted. A write made during an active frame does not change that frame and is sent in the next one.
- R5: `frame_done_o` is a one-cycle pulse, raised when select is deasserted after exactly 48 rising serial clock edges.
- R6: `frame_err_o` is a one-cycle pulse, raised when select is deasserted after any other number of rising edges, fewer or more than 48. The bit count saturates past 48, so longer frames are still flagged.
- R7: Each select assertion restarts the bit count and reloads the shift register. A frame that follows an errored frame is served correctly.
- R8: `miso_oe_o` follows the inverse of `ssn_i` two system clocks after the input changes, because of the two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| ssn_i | input | 1 | Active-low frame select from the master |
| rsp_data_i | input | RSP_W | Response word from local logic |
| rsp_valid_i | input | 1 | Strobe that loads `rsp_data_i` into the holding register |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o`, high during a frame |
| frame_done_o | output | 1 | One-cycle pulse: frame closed after exactly 48 bits |
| frame_err_o | output | 1 | One-cycle pulse: frame closed at any other bit count |

## Verification
The hardest case to reach from the ports is a holding-register write that lands in the middle of a live frame while the serial clock keeps running. The bench pulses the strobe just after the 20th rising edge. It then checks that the rest of that frame still carries the old word and that the following frame carries the new one. The bench also closes frames early and late, and then confirms that the next full frame is served from a clean count. A behavioural model that delays the pins by history queues tracks every output on every system clock.

// File: rtl/spisl_pkg.sv
package spisl_pkg;

    localparam int HDR_BITS_DEF = 16;
    localparam int RSP_BITS_DEF = 32;
    localparam int SYNC_STAGES  = 2;

    typedef struct packed {
        logic sclk;
        logic ssn;
    } pins_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } evt_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, ssn: 1'b1};

    function automatic int cnt_width(input int frame_bits);
        return $clog2(frame_bits + 2);
    endfunction

endpackage

// File: rtl/spisl_sync.sv
module spisl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spisl_framer.sv
module spisl_framer
    import spisl_pkg::*;
#(
    parameter int HDR_W = HDR_BITS_DEF,
    parameter int RSP_W = RSP_BITS_DEF,
    localparam int FRAME_W = HDR_W + RSP_W,
    localparam int CNT_W   = cnt_width(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  pins_t            pins_s,
    output evt_t             evt,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             done,
    output logic             err
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic sclk_q;
    logic ssn_q;

    always_comb begin
        evt.start = ssn_q  & ~pins_s.ssn;
        evt.stop  = ~ssn_q &  pins_s.ssn;
        evt.rise  = ~pins_s.ssn &  pins_s.sclk & ~sclk_q;
        evt.fall  = ~pins_s.ssn & ~pins_s.sclk &  sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= PINS_IDLE.sclk;
            ssn_q   <= PINS_IDLE.ssn;
            bit_cnt <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            sclk_q <= pins_s.sclk;
            ssn_q  <= pins_s.ssn;
            done   <= 1'b0;
            err    <= 1'b0;
            if (evt.start) begin
                bit_cnt <= '0;
            end else if (evt.stop) begin
                done    <= (bit_cnt == CNT_FULL);
                err     <= (bit_cnt != CNT_FULL);
                bit_cnt <= '0;
            end else if (evt.rise && bit_cnt != CNT_SAT) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spisl_txpath.sv
module spisl_txpath
    import spisl_pkg::*;
#(
    parameter int HDR_W = HDR_BITS_DEF,
    parameter int RSP_W = RSP_BITS_DEF,
    localparam int FRAME_W = HDR_W + RSP_W,
    localparam int CNT_W   = cnt_width(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RSP_W-1:0] rsp_data,
    input  logic             rsp_valid,
    input  evt_t             evt,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             active,
    output logic             miso,
    output logic             miso_oe
);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_SHIFT = CNT_W'(HDR_W + 1);

    logic [RSP_W-1:0] hold_q;
    logic [RSP_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (rsp_valid) hold_q <= rsp_data;
            if (evt.start)
                shreg_q <= hold_q;
            else if (evt.fall && bit_cnt >= CNT_SHIFT)
                shreg_q <= {shreg_q[RSP_W-2:0], 1'b0};
        end
    end

    assign miso_oe = active;
    assign miso    = active && (bit_cnt >= CNT_FIRST) && shreg_q[RSP_W-1];
endmodule

// File: rtl/fixed_frame_spi_slave.sv
module fixed_frame_spi_slave
    import spisl_pkg::*;
#(
    parameter int HDR_W = HDR_BITS_DEF,
    parameter int RSP_W = RSP_BITS_DEF,
    localparam int FRAME_W = HDR_W + RSP_W,
    localparam int CNT_W   = cnt_width(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             ssn_i,
    input  logic [RSP_W-1:0] rsp_data_i,
    input  logic             rsp_valid_i,
    output logic             miso_o,
    output logic             miso_oe_o,
    output logic             frame_done_o,
    output logic             frame_err_o
);
    pins_t            pins_raw;
    pins_t            pins_s;
    evt_t             evt;
    logic [CNT_W-1:0] bit_cnt;

    assign pins_raw = '{sclk: sclk_i, ssn: ssn_i};

    spisl_sync #(
        .W      ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins_raw),
        .dout(pins_s)
    );

    spisl_framer #(.HDR_W(HDR_W), .RSP_W(RSP_W)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .evt    (evt),
        .bit_cnt(bit_cnt),
        .done   (frame_done_o),
        .err    (frame_err_o)
    );

    spisl_txpath #(.HDR_W(HDR_W), .RSP_W(RSP_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .rsp_data (rsp_data_i),
        .rsp_valid(rsp_valid_i),
        .evt      (evt),
        .bit_cnt  (bit_cnt),
        .active   (~pins_s.ssn),
        .miso     (miso_o),
        .miso_oe  (miso_oe_o)
    );
endmodule

// File: rtl/spisl_checker.sv
module spisl_checker #(
    parameter int HDR_W = 16,
    parameter int RSP_W = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             miso_o,
    input logic             miso_oe_o,
    input logic             frame_done_o,
    input logic             frame_err_o,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HDR_W + RSP_W);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !miso_oe_o |-> !miso_o);

    assert_header_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (miso_oe_o && bit_cnt < CNT_HDR) |-> !miso_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    assert_done_full_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done_o) |-> ($past(bit_cnt) == CNT_FULL));

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_done_o, frame_err_o}));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_done_o || frame_err_o) |-> (bit_cnt == '0));
endmodule

bind fixed_frame_spi_slave spisl_checker #(
    .HDR_W(HDR_W),
    .RSP_W(RSP_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o),
    .frame_done_o(frame_done_o),
    .frame_err_o (frame_err_o),
    .bit_cnt     (bit_cnt)
);

// File: tb/test_fixed_frame_spi_slave.sv
module test_fixed_frame_spi_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_i = 1'b0;
    logic        ssn_i = 1'b1;
    logic [31:0] rsp_data_i = '0;
    logic        rsp_valid_i = 1'b0;
    logic        miso_o, miso_oe_o, frame_done_o, frame_err_o;

    int errors = 0;
    int checks = 0;
    int n_done = 0;
    int n_err  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fixed_frame_spi_slave i_fixed_frame_spi_slave (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .ssn_i(ssn_i),
        .rsp_data_i(rsp_data_i), .rsp_valid_i(rsp_valid_i),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o),
        .frame_done_o(frame_done_o), .frame_err_o(frame_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: pin history queues, frame counter, words.
    bit hss[4];
    bit hsc[4];
    int          m_cnt;
    logic [31:0] m_hold, m_shr;
    bit          m_done, m_err;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hss[i] = 1'b1; hsc[i] = 1'b0; end
            m_cnt = 0; m_hold = '0; m_shr = '0; m_done = 0; m_err = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin hss[i] = hss[i-1]; hsc[i] = hsc[i-1]; end
            hss[0] = ssn_i;
            hsc[0] = sclk_i;
            m_done = 0;
            m_err  = 0;
            if (hss[3] && !hss[2]) begin
                m_cnt = 0;
                m_shr = m_hold;
            end else if (!hss[3] && hss[2]) begin
                m_done = (m_cnt == 48);
                m_err  = (m_cnt != 48);
                m_cnt  = 0;
            end else if (!hss[2] && hsc[2] && !hsc[3]) begin
                if (m_cnt < 49) m_cnt++;
            end else if (!hss[2] && !hsc[2] && hsc[3] && m_cnt >= 17) begin
                m_shr = m_shr << 1;
            end
            if (rsp_valid_i) m_hold = rsp_data_i;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit e_oe, e_miso;
            e_oe   = !hss[1];
            e_miso = e_oe && (m_cnt >= 16) && m_shr[31];
            check(miso_oe_o == e_oe, "R8 model oe", miso_oe_o, e_oe);
            check(miso_o == e_miso, "R3 model miso", miso_o, e_miso);
            check(frame_done_o == m_done, "R5 model done", frame_done_o, m_done);
            check(frame_err_o == m_err, "R6 model err", frame_err_o, m_err);
            if (frame_done_o) n_done++;
            if (frame_err_o)  n_err++;
        end
    end

    task automatic load(input logic [31:0] v);
        rsp_data_i = v; rsp_valid_i = 1'b1;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input int nbits, input bit mid_wr, input logic [31:0] wr_val,
                             output logic [31:0] rx, output bit hdr_nz);
        rx = '0; hdr_nz = 1'b0;
        ssn_i = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 1; b <= nbits; b++) begin
            repeat (HALF) @(negedge clk);
            if (b <= 16) hdr_nz |= miso_o;
            else if (b <= 48) rx = {rx[30:0], miso_o};
            sclk_i = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk_i = 1'b0;
            if (mid_wr && b == 20) begin
                rsp_data_i = wr_val; rsp_valid_i = 1'b1;
                @(negedge clk);
                rsp_valid_i = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        ssn_i = 1'b1;
        repeat (3*HALF) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rx;
        bit hnz;
        int d0, e0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(miso_oe_o == 0 && miso_o == 0, "R1 reset miso/oe", {miso_oe_o, miso_o}, 0);
        check(frame_done_o == 0 && frame_err_o == 0, "R1 reset pulses",
              {frame_done_o, frame_err_o}, 0);

        // R1: serial clock toggling with select high
        d0 = n_done; e0 = n_err;
        for (int i = 0; i < 6; i++) begin
            sclk_i = 1'b1; repeat (HALF) @(negedge clk);
            sclk_i = 1'b0; repeat (HALF) @(negedge clk);
            check(miso_oe_o == 0 && miso_o == 0, "R1 idle clocks", {miso_oe_o, miso_o}, 0);
        end
        check(n_done == d0 && n_err == e0, "R1 idle no pulse", n_done + n_err, d0 + e0);

        // R8: enable latency of two system clocks
        ssn_i = 1'b0;
        @(negedge clk);
        check(miso_oe_o == 0, "R8 oe after 1 clk", miso_oe_o, 0);
        @(negedge clk);
        check(miso_oe_o == 1, "R8 oe after 2 clk", miso_oe_o, 1);
        ssn_i = 1'b1;
        @(negedge clk);
        check(miso_oe_o == 1, "R8 oe drop after 1 clk", miso_oe_o, 1);
        @(negedge clk);
        check(miso_oe_o == 0, "R8 oe drop after 2 clk", miso_oe_o, 0);
        repeat (3*HALF) @(negedge clk);

        // Full frame (R2 R3 R4 R5); the short select blip above flagged one error
        load(32'hA5C3_0F96);
        d0 = n_done; e0 = n_err;
        run_frame(48, 0, '0, rx, hnz);
        check(hnz == 0, "R2 header zero", hnz, 0);
        check(rx == 32'hA5C3_0F96, "R3 response word", rx, 32'hA5C3_0F96);
        check(n_done == d0 + 1, "R5 done pulse", n_done - d0, 1);
        check(n_err == e0, "R5 no err on full", n_err - e0, 0);

        // Second pattern, all ones and alternating
        load(32'hFFFF_FFFF);
        run_frame(48, 0, '0, rx, hnz);
        check(rx == 32'hFFFF_FFFF && hnz == 0, "R3 all ones", rx, 32'hFFFF_FFFF);
        load(32'h5555_AAAA);
        run_frame(48, 0, '0, rx, hnz);
        check(rx == 32'h5555_AAAA, "R4 loaded word", rx, 32'h5555_AAAA);

        // R4: write during an active frame applies to the next frame
        load(32'h1234_5678);
        run_frame(48, 1, 32'h8765_4321, rx, hnz);
        check(rx == 32'h1234_5678, "R4 mid write not in frame", rx, 32'h1234_5678);
        run_frame(48, 0, '0, rx, hnz);
        check(rx == 32'h8765_4321, "R4 mid write next frame", rx, 32'h8765_4321);

        // R6: short frame, then R7 recovery
        load(32'hC0DE_F00D);
        d0 = n_done; e0 = n_err;
        run_frame(8, 0, '0, rx, hnz);
        check(n_err == e0 + 1 && n_done == d0, "R6 short frame err", n_err - e0, 1);
        run_frame(48, 0, '0, rx, hnz);
        check(rx == 32'hC0DE_F00D, "R7 frame after short", rx, 32'hC0DE_F00D);
        check(n_done == d0 + 1, "R7 done after short", n_done - d0, 1);

        // R6: long frame (count saturates)
        d0 = n_done; e0 = n_err;
        run_frame(52, 0, '0, rx, hnz);
        check(rx == 32'hC0DE_F00D, "R6 long frame data", rx, 32'hC0DE_F00D);
        check(n_err == e0 + 1 && n_done == d0, "R6 long frame err", n_err - e0, 1);
        run_frame(48, 0, '0, rx, hnz);
        check(rx == 32'hC0DE_F00D && n_done == d0 + 1, "R7 frame after long", rx, 32'hC0DE_F00D);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule